// File: doc/BRIEF.md
# Parallel Port FIFO Service-Interrupt Controller

This block decides when a parallel port with a 16-byte FIFO has to ask the host for attention. It watches the FIFO fill level, the transfer direction, the DMA enable and the DMA terminal-count strobe, together with two peripheral status lines: the fault line and the acknowledge line, both active low. From these it produces a DMA service request and a shareable interrupt. The interrupt is a short low pulse, after which the line is released to high impedance.

Service interrupts are level conditions gated by a mask bit. When the mask bit is 0, DMA mode interrupts on the terminal count. Programmed-I/O mode interrupts once the FIFO has reached a programmable threshold of free bytes (host to peripheral) or stored bytes (peripheral to host). When a service interrupt fires, hardware sets the mask bit, so the condition does not fire again until software clears the mask. If the condition is still true when software clears the mask, the interrupt fires at once. Separate status interrupts come from the fault and acknowledge lines. These two lines are synchronised and edge-detected inside the block.

The FIFO storage, the host bus decoding and the port handshake machines are outside this block. They supply the fill count, the control bits and the status lines.

Top module: `ppFifoIrqCtl`

## Requirements
- R1: Reset leaves the mask bit at 1, `irqOe` at 0 and `dmaReq` at 0. While the mask bit reads 1, `dmaReq` stays 0 and no service interrupt fires; a terminal-count strobe is ignored.
- R2: With mask 0, `dmaEn` 1 and `fifoEnable` 1, a one-cycle `tcStrobe` makes `irqOe` rise after the next clock edge. In DMA mode the FIFO level alone never fires a service interrupt.
- R3: With mask 0, `dmaEn` 0 and `direction` 0, a service interrupt fires when `16 - fifoCount >= thrField + 1`. When a count change makes this true, `irqOe` rises after the next clock edge.
- R4: With mask 0, `dmaEn` 0 and `direction` 1, a service interrupt fires when `fifoCount >= thrField + 1`. With `thrField` at 15 this needs a full FIFO of 16 bytes.
- R5: A write of 0 to the mask while the service condition already holds fires the interrupt with no byte moving. `irqOe` rises after the second clock edge from the write.
- R6: When a service interrupt fires, hardware sets the mask bit to 1 on the same edge that starts the pulse.
- R7: With `errIntrEnN` at 0, a high-to-low change of `nFault` raises `irqOe` after the third clock edge. A 1-to-0 change of `errIntrEnN` while `nFault` is already low raises `irqOe` after the first clock edge. With `errIntrEnN` at 1, a fall of `nFault` has no effect.
- R8: With `ackIntrEn` at 1, a low-to-high change of `nAck` raises `irqOe` after the third clock edge. With `ackIntrEn` at 0, or on a falling `nAck`, there is no interrupt.
- R9: Every interrupt holds `irqOe` at 1 for exactly PULSE_LEN (default 4) cycles, with `irqOut` at 0. Afterwards `irqOe` is 0, which releases the line.
- R10: While `fifoEnable` is 0, no service interrupt fires and `dmaReq` is 0, even with the mask at 0.
- R11: `dmaReq` is 1 only when `fifoEnable` is 1, `dmaEn` is 1 and the mask is 0, and the FIFO can move a byte: it has free space when `direction` is 0, or holds data when `direction` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEnable | input | 1 | FIFO mode selected |
| fifoCount | input | 5 | Bytes held in the FIFO, 0 to 16 |
| direction | input | 1 | 0 = host to peripheral, 1 = peripheral to host |
| dmaEn | input | 1 | DMA mode enable |
| tcStrobe | input | 1 | DMA terminal-count pulse |
| thrField | input | 4 | Threshold minus one |
| maskWrEn | input | 1 | Software write strobe for the mask bit |
| maskWrData | input | 1 | Value written to the mask bit |
| errIntrEnN | input | 1 | Error interrupt enable, active low |
| ackIntrEn | input | 1 | Acknowledge interrupt enable |
| nFault | input | 1 | Peripheral fault line, asynchronous |
| nAck | input | 1 | Peripheral acknowledge line, asynchronous |
| maskOut | output | 1 | Current mask bit |
| dmaReq | output | 1 | DMA service request |
| irqOe | output | 1 | Interrupt line drive enable |
| irqOut | output | 1 | Interrupt line value while driven (0) |

## Verification
The hardest cases to reach are the two re-arming paths. In one, the mask is cleared while the threshold condition is already true and the interrupt has to fire with no byte moving. In the other, the error enable drops while the fault line is already low. The stimulus sets up the FIFO level or the fault line first, with the mask or the enable still blocking, waits until any pending event has drained, and only then releases the gate. This separates the re-arm event from the level or edge that created the condition. Threshold corners are driven one byte on each side, and each expected pulse is queued with its exact rise cycle.

// File: rtl/ppIrqPkg.sv
package ppIrqPkg;
  typedef struct packed {
    logic svcCond;
    logic errEvt;
    logic ackEvt;
    logic dmaReady;
  } irqCondT;

  typedef struct packed {
    logic firePulse;
  } irqStrobeT;
endpackage

// File: rtl/ppIrqDatapath.sv
module ppIrqDatapath
  import ppIrqPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PULSE_LEN = 4,
  parameter int SYNC_LEN  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  input  logic                         direction,
  input  logic                         dmaEn,
  input  logic                         tcStrobe,
  input  logic [$clog2(DEPTH)-1:0]     thrField,
  input  logic                         errIntrEnN,
  input  logic                         ackIntrEn,
  input  logic                         nFault,
  input  logic                         nAck,
  input  irqStrobeT                    strobe,
  output irqCondT                      cond,
  output logic                         irqOe
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int THR_W   = $clog2(DEPTH);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0]   DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PULSE_W-1:0] PULSE_C = PULSE_W'(PULSE_LEN);

  // synchronisers, index 0 = nFault, 1 = nAck
  logic [1:0] rawIn;
  logic [1:0] syncOut;
  logic [1:0] syncPrev;
  assign rawIn = {nAck, nFault};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_LEN-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage       <= '1;
        syncPrev[g] <= 1'b1;
      end else begin
        stage       <= {stage[SYNC_LEN-2:0], rawIn[g]};
        syncPrev[g] <= stage[SYNC_LEN-1];
      end
    end
    assign syncOut[g] = stage[SYNC_LEN-1];
  end

  logic errEnPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errEnPrev <= 1'b0;
    else       errEnPrev <= errIntrEnN;
  end

  logic faultFall, ackRise, errEnFall;
  assign faultFall = syncPrev[0] & ~syncOut[0];
  assign ackRise   = ~syncPrev[1] & syncOut[1];
  assign errEnFall = errEnPrev & ~errIntrEnN;

  // threshold compare
  logic [CNT_W-1:0] thrVal;
  logic [CNT_W-1:0] freeCnt;
  logic             wrReady, rdReady;
  assign thrVal  = CNT_W'({1'b0, thrField}) + CNT_W'(1);
  assign freeCnt = DEPTH_C - fifoCount;
  assign wrReady = freeCnt >= thrVal;
  assign rdReady = fifoCount >= thrVal;

  always_comb begin
    cond.svcCond  = dmaEn ? tcStrobe : (direction ? rdReady : wrReady);
    cond.errEvt   = ~errIntrEnN & ~syncOut[0] & (faultFall | errEnFall);
    cond.ackEvt   = ackIntrEn & ackRise;
    cond.dmaReady = direction ? (fifoCount != '0) : (fifoCount < DEPTH_C);
  end

  // pulse stretcher
  logic [PULSE_W-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strobe.firePulse) pulseCnt <= PULSE_C;
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - PULSE_W'(1);
  end
  assign irqOe = pulseCnt != '0;

  logic unusedThr;
  assign unusedThr = ^THR_W;
endmodule

// File: rtl/ppIrqControl.sv
module ppIrqControl
  import ppIrqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fifoEnable,
  input  logic      dmaEn,
  input  logic      maskWrEn,
  input  logic      maskWrData,
  input  irqCondT   cond,
  output irqStrobeT strobe,
  output logic      maskOut,
  output logic      dmaReq
);
  logic maskBit;
  logic svcFire;

  assign svcFire = fifoEnable & ~maskBit & cond.svcCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         maskBit <= 1'b1;
    else if (svcFire)  maskBit <= 1'b1;
    else if (maskWrEn) maskBit <= maskWrData;
  end

  always_comb begin
    strobe.firePulse = svcFire | cond.errEvt | cond.ackEvt;
  end

  assign maskOut = maskBit;
  assign dmaReq  = fifoEnable & dmaEn & ~maskBit & cond.dmaReady;
endmodule

// File: rtl/ppFifoIrqCtl.sv
module ppFifoIrqCtl
  import ppIrqPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PULSE_LEN = 4,
  parameter int SYNC_LEN  = 2,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int THR_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEnable,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             direction,
  input  logic             dmaEn,
  input  logic             tcStrobe,
  input  logic [THR_W-1:0] thrField,
  input  logic             maskWrEn,
  input  logic             maskWrData,
  input  logic             errIntrEnN,
  input  logic             ackIntrEn,
  input  logic             nFault,
  input  logic             nAck,
  output logic             maskOut,
  output logic             dmaReq,
  output logic             irqOe,
  output logic             irqOut
);
  irqCondT   cond;
  irqStrobeT strobe;

  ppIrqDatapath #(.DEPTH(DEPTH), .PULSE_LEN(PULSE_LEN), .SYNC_LEN(SYNC_LEN)) uData (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .direction(direction),
    .dmaEn(dmaEn), .tcStrobe(tcStrobe), .thrField(thrField),
    .errIntrEnN(errIntrEnN), .ackIntrEn(ackIntrEn), .nFault(nFault), .nAck(nAck),
    .strobe(strobe), .cond(cond), .irqOe(irqOe)
  );

  ppIrqControl uCtrl (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .dmaEn(dmaEn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .cond(cond),
    .strobe(strobe), .maskOut(maskOut), .dmaReq(dmaReq)
  );

  assign irqOut = 1'b0;
endmodule

// File: rtl/ppFifoIrqCtlChk.sv
module ppFifoIrqCtlChk (
  input logic clk,
  input logic rstN,
  input logic fifoEnable,
  input logic dmaEn,
  input logic tcStrobe,
  input logic maskOut,
  input logic dmaReq,
  input logic irqOe
);
  assert_mask_blocks_dma_R1: assert property (@(posedge clk) disable iff (!rstN)
    maskOut |-> !dmaReq);

  assert_disabled_no_dma_R10: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEnable |-> !dmaReq);

  assert_tc_fires_and_masks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!maskOut && dmaEn && fifoEnable && tcStrobe) |=> (irqOe && maskOut));

  assert_pulse_not_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOe) |=> irqOe);
endmodule

bind ppFifoIrqCtl ppFifoIrqCtlChk uChk (
  .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .dmaEn(dmaEn),
  .tcStrobe(tcStrobe), .maskOut(maskOut), .dmaReq(dmaReq), .irqOe(irqOe)
);

// File: tb/tb_ppFifoIrqCtl.sv
`timescale 1ns/1ps
module tb_ppFifoIrqCtl;
  localparam int PULSE_LEN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEnable = 0, direction = 0, dmaEn = 0, tcStrobe = 0;
  logic [4:0] fifoCount = '0;
  logic [3:0] thrField = '0;
  logic maskWrEn = 0, maskWrData = 0, errIntrEnN = 1, ackIntrEn = 0;
  logic nFault = 1, nAck = 1;
  logic maskOut, dmaReq, irqOe, irqOut;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expQ[$];
  string expTag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ppFifoIrqCtl dut (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .fifoCount(fifoCount),
    .direction(direction), .dmaEn(dmaEn), .tcStrobe(tcStrobe), .thrField(thrField),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .errIntrEnN(errIntrEnN),
    .ackIntrEn(ackIntrEn), .nFault(nFault), .nAck(nAck),
    .maskOut(maskOut), .dmaReq(dmaReq), .irqOe(irqOe), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver side: queue an expected pulse rise lat edges from now
  task automatic expectRise(input int lat, input string tag);
    expQ.push_back(cyc + lat);
    expTag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeMask(input logic v);
    maskWrEn = 1; maskWrData = v;
    @(negedge clk);
    maskWrEn = 0;
  endtask

  task automatic drain(input string tag);
    idle(12);
    check(expQ.size() == 0, {tag, " pending pulses"}, expQ.size(), 0);
  endtask

  // monitor: compare each rise with the queue, measure width
  logic prevOe = 0;
  int width = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (irqOe && !prevOe) begin
        if (expQ.size() == 0) begin
          check(0, "unexpected pulse", cyc, -1);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = expTag.pop_front();
          check(cyc == e, t, cyc, e);
        end
        check(irqOut == 1'b0, "R9 line value", irqOut, 0);
        width = 1;
      end else if (irqOe) begin
        width++;
      end else if (prevOe) begin
        check(width == PULSE_LEN, "R9 pulse width", width, PULSE_LEN);
      end
      prevOe = irqOe;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(5);
    rstN = 1;
    @(negedge clk); #1;
    check(irqOe == 0, "R1 reset irqOe", irqOe, 0);
    check(maskOut == 1, "R1 reset mask", maskOut, 1);
    check(dmaReq == 0, "R1 reset dmaReq", dmaReq, 0);

    // R10: disabled FIFO, mask cleared, condition true -> nothing
    thrField = 4'd3; fifoCount = 5'd0; direction = 0;
    @(negedge clk); writeMask(0);
    idle(10);
    check(maskOut == 0, "R10 mask stays clear", maskOut, 0);
    dmaEn = 1; #1;
    check(dmaReq == 0, "R10 no dmaReq when disabled", dmaReq, 0);
    dmaEn = 0;
    drain("R10");

    // R3 + R6: enable with free 16 >= 4
    fifoEnable = 1; expectRise(1, "R3 write threshold");
    idle(1); #1;
    check(maskOut == 1, "R6 mask set by hardware", maskOut, 1);
    drain("R3");

    // R5: clear mask with condition already valid
    maskWrEn = 1; maskWrData = 0; expectRise(2, "R5 clear re-fires");
    @(negedge clk); maskWrEn = 0;
    drain("R5");

    // R3 boundary: free 3 < 4, then free 4
    fifoCount = 5'd13;
    writeMask(0);
    idle(10);
    check(maskOut == 0, "R3 below threshold no fire", maskOut, 0);
    fifoCount = 5'd12; expectRise(1, "R3 at threshold");
    drain("R3 boundary");

    // R4: read direction, threshold 16
    direction = 1; thrField = 4'd15; fifoCount = 5'd15;
    writeMask(0);
    idle(10);
    check(maskOut == 0, "R4 15 of 16 no fire", maskOut, 0);
    fifoCount = 5'd16; expectRise(1, "R4 full fires");
    drain("R4");

    // R2: DMA mode ignores level, fires on terminal count
    dmaEn = 1;
    writeMask(0);
    idle(10); #1;
    check(maskOut == 0, "R2 level ignored in DMA", maskOut, 0);
    check(dmaReq == 1, "R11 read dmaReq with data", dmaReq, 1);
    fifoCount = 5'd0; #1;
    check(dmaReq == 0, "R11 read dmaReq empty", dmaReq, 0);
    fifoCount = 5'd16;
    @(negedge clk);
    tcStrobe = 1; expectRise(1, "R2 terminal count");
    @(negedge clk); tcStrobe = 0; #1;
    check(maskOut == 1, "R6 mask set after tc", maskOut, 1);
    check(dmaReq == 0, "R1 masked dmaReq", dmaReq, 0);
    drain("R2");

    // R1: tc while masked is ignored
    tcStrobe = 1; @(negedge clk); tcStrobe = 0;
    drain("R1 masked tc");

    // R11: write direction request
    direction = 0; fifoCount = 5'd16;
    writeMask(0); #1;
    check(dmaReq == 0, "R11 write dmaReq full", dmaReq, 0);
    fifoCount = 5'd15; #1;
    check(dmaReq == 1, "R11 write dmaReq space", dmaReq, 1);
    @(negedge clk); writeMask(1); #1;
    check(dmaReq == 0, "R1 mask set drops dmaReq", dmaReq, 0);
    dmaEn = 0;
    drain("R11");

    // R7: error interrupt paths
    errIntrEnN = 0; idle(6);
    nFault = 0; expectRise(3, "R7 fault fall");
    drain("R7 fall");
    errIntrEnN = 1; idle(4);
    errIntrEnN = 0; expectRise(1, "R7 enable drop while low");
    drain("R7 enable");
    errIntrEnN = 1; nFault = 1; idle(6);
    nFault = 0;
    drain("R7 disabled fall");
    nFault = 1; idle(6);

    // R8: acknowledge interrupt
    ackIntrEn = 1; nAck = 0;
    drain("R8 falling ignored");
    nAck = 1; expectRise(3, "R8 ack rise");
    drain("R8 rise");
    ackIntrEn = 0; nAck = 0; idle(6);
    nAck = 1;
    drain("R8 disabled");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule